// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block is the software-visible register bank of an I/O address translation unit. A host bus issues 32-bit reads and writes at byte offsets. Every register applies its own write mask and some force fixed bits to one, so that software can never store a value the hardware does not support. Read data is returned combinationally in the cycle of the access. Accesses that do not carry all four byte enables, and offsets that map to no register, have no effect and read as zero.

The control register holds a 3-bit window-size code. On every control write the bank derives the lowest address of the translated window and presents it on `winStart` from the next cycle on. The translator next to the bank reports a failed lookup on a one-cycle capture strobe. The strobe loads the fault status and fault address registers and raises a level interrupt. Any full-word read or write of either fault register lowers the interrupt again. The arbiter, arbitration-enable and slot-configuration registers are plain masked storage. The mask-identity register can only gain bits.

Top module: `ioxlat_csr`

## Requirements
- R1: After reset the registers read as follows: control = VERSION_BYTE in bits [31:24] and zero elsewhere; arbitration enable (0x2000) = 0x00000008; fault status (0x1000) = 0x00800000; arbiter enable (0x1008) = 0x00000003; mask identity (0x3018) = 0x23000000; every other register = 0. `irqOut` is low and `winStart` is 0.
- R2: A write to control (0x0000) stores the written value ANDed with 0x0000001D, with VERSION_BYTE ORed into bits [31:24].
- R3: `winStart` changes only on a control write. From the cycle after that write it equals 0xFF000000 shifted left by the code in bits [4:2] of the written value, kept to 32 bits: code 0 gives 0xFF000000 (16 MB) and code 7 gives 0x80000000 (2 GB).
- R4: A write to the table base (0x0004) keeps only the bits in 0x07FFFC00. The full-flush (0x0014) and page-flush (0x0018) registers store all 32 bits.
- R5: A write to fault status (0x1000) keeps the bits in 0xFF0FFFFF and forces bit 23 to one.
- R6: A write to the arbiter enable (0x1008) is masked with 0x801F000F and forces bit 0. A write to the arbitration enable (0x2000) is masked with 0x001F0000 and forces bit 3. The slot configurations at 0x1010, 0x1014, 0x1018 and 0x101C each keep the bits in 0x00010003.
- R7: A write to the mask identity (0x3018) ORs bits [23:0] of the value into the register. No write clears any bit.
- R8: An access whose byte enables are not all ones changes no register and no interrupt state, and it reads as zero.
- R9: An offset that names no register, including an unaligned one, reads as zero, and a write to it changes nothing.
- R10: A capture strobe loads fault status with 0xC0820000, ORed with 0x00040000 when the failed access was a read (`faultWrite` low). It loads fault address with `faultAddr` with bits [11:0] cleared, and it drives `irqOut` high from the next cycle.
- R11: A full-word read or write of fault status or fault address, in a cycle with no capture strobe, drives `irqOut` low from the next cycle.
- R12: When a capture strobe and a bus write or access to a fault register fall in the same cycle, the captured values and the raised interrupt take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busBe | input | 4 | Byte enables; only 4'b1111 takes effect |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| faultCapture | input | 1 | One-cycle strobe from the translator reporting a fault |
| faultWrite | input | 1 | The faulting access was a write |
| faultAddr | input | 32 | Address of the faulting access |
| irqOut | output | 1 | Level fault interrupt |
| winStart | output | 32 | Lowest address of the translated window |

## Verification
The hardest case is a capture strobe that coincides with a bus write or read of a fault register, because two sources then update the same state in one cycle. The bench drives that collision with both the status and the address register as the bus target, then reads the registers back to confirm that the captured values stayed. It also confirms that a partial-byte-enable read of the status register left the interrupt raised, and that a later full-word access still clears it.

// File: rtl/ioxlat_csr_pkg.sv
package ioxlat_csr_pkg;

  localparam int NUM_SLOTS = 4;

  localparam int OFS_CTRL  = 'h0000;
  localparam int OFS_BASE  = 'h0004;
  localparam int OFS_TLBF  = 'h0014;
  localparam int OFS_PGF   = 'h0018;
  localparam int OFS_STAT  = 'h1000;
  localparam int OFS_FADDR = 'h1004;
  localparam int OFS_ARB   = 'h1008;
  localparam int OFS_SLOT0 = 'h1010;
  localparam int OFS_ARBEN = 'h2000;
  localparam int OFS_MASK  = 'h3018;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
  localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
  localparam logic [31:0] STAT_KEEP   = 32'hFF0F_FFFF;
  localparam logic [31:0] STAT_FORCE  = 32'h0080_0000;
  localparam logic [31:0] ARB_KEEP    = 32'h801F_000F;
  localparam logic [31:0] ARB_FORCE   = 32'h0000_0001;
  localparam logic [31:0] ARBEN_KEEP  = 32'h001F_0000;
  localparam logic [31:0] ARBEN_FORCE = 32'h0000_0008;
  localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
  localparam logic [31:0] MASK_KEEP   = 32'h00FF_FFFF;
  localparam logic [31:0] MASK_RESET  = 32'h2300_0000;
  localparam logic [31:0] ARB_RESET   = 32'h0000_0003;
  localparam logic [31:0] CAP_STATUS  = 32'hC082_0000;
  localparam logic [31:0] CAP_RDBIT   = 32'h0004_0000;
  localparam logic [31:0] PAGE_KEEP   = 32'hFFFF_F000;
  localparam logic [31:0] WIN_SMALL   = 32'hFF00_0000;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_BASE, RD_TLBF, RD_PGF, RD_STAT,
    RD_FADDR, RD_ARB, RD_SLOT, RD_ARBEN, RD_MASK
  } rdSel_e;

  typedef struct packed {
    logic                 wrCtrl;
    logic                 wrBase;
    logic                 wrTlbf;
    logic                 wrPgf;
    logic                 wrStat;
    logic                 wrFaddr;
    logic                 wrArb;
    logic                 wrArbEn;
    logic                 wrMask;
    logic [NUM_SLOTS-1:0] wrSlot;
    logic                 faultTouch;
  } csrStrobe_t;

endpackage

// File: rtl/ioxlat_csr_ctrl.sv
module ioxlat_csr_ctrl
  import ioxlat_csr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  output csrStrobe_t        strobe,
  output rdSel_e            rdSel,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIdx
);
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BASE);
  localparam logic [ADDR_W-1:0] A_TLBF  = ADDR_W'(OFS_TLBF);
  localparam logic [ADDR_W-1:0] A_PGF   = ADDR_W'(OFS_PGF);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_FADDR = ADDR_W'(OFS_FADDR);
  localparam logic [ADDR_W-1:0] A_ARB   = ADDR_W'(OFS_ARB);
  localparam logic [ADDR_W-1:0] A_SLOT0 = ADDR_W'(OFS_SLOT0);
  localparam logic [ADDR_W-1:0] A_SLOTE = ADDR_W'(OFS_SLOT0 + 4 * NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_ARBEN = ADDR_W'(OFS_ARBEN);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

  logic              fullAcc, wrAcc, rdAcc, inSlots;
  logic [ADDR_W-1:0] slotOff;
  rdSel_e            hitSel;

  assign fullAcc = busSel && (&busBe);
  assign wrAcc   = fullAcc && busWrite;
  assign rdAcc   = fullAcc && !busWrite;
  assign slotOff = busAddr - A_SLOT0;
  assign inSlots = (busAddr >= A_SLOT0) && (busAddr < A_SLOTE) && (busAddr[1:0] == 2'b00);

  always_comb begin
    hitSel = RD_NONE;
    if (inSlots) hitSel = RD_SLOT;
    else begin
      case (busAddr)
        A_CTRL:  hitSel = RD_CTRL;
        A_BASE:  hitSel = RD_BASE;
        A_TLBF:  hitSel = RD_TLBF;
        A_PGF:   hitSel = RD_PGF;
        A_STAT:  hitSel = RD_STAT;
        A_FADDR: hitSel = RD_FADDR;
        A_ARB:   hitSel = RD_ARB;
        A_ARBEN: hitSel = RD_ARBEN;
        A_MASK:  hitSel = RD_MASK;
        default: hitSel = RD_NONE;
      endcase
    end
  end

  always_comb begin
    slotIdx           = slotOff[2 +: SLOT_IDX_W];
    rdSel             = rdAcc ? hitSel : RD_NONE;
    strobe            = '0;
    strobe.wrCtrl     = wrAcc && (hitSel == RD_CTRL);
    strobe.wrBase     = wrAcc && (hitSel == RD_BASE);
    strobe.wrTlbf     = wrAcc && (hitSel == RD_TLBF);
    strobe.wrPgf      = wrAcc && (hitSel == RD_PGF);
    strobe.wrStat     = wrAcc && (hitSel == RD_STAT);
    strobe.wrFaddr    = wrAcc && (hitSel == RD_FADDR);
    strobe.wrArb      = wrAcc && (hitSel == RD_ARB);
    strobe.wrArbEn    = wrAcc && (hitSel == RD_ARBEN);
    strobe.wrMask     = wrAcc && (hitSel == RD_MASK);
    strobe.faultTouch = fullAcc && ((hitSel == RD_STAT) || (hitSel == RD_FADDR));
    for (int i = 0; i < NUM_SLOTS; i++)
      strobe.wrSlot[i] = wrAcc && (hitSel == RD_SLOT) && (int'(slotIdx) == i);
  end

endmodule

// File: rtl/ioxlat_csr_dp.sv
module ioxlat_csr_dp
  import ioxlat_csr_pkg::*;
#(
  parameter logic [7:0] VERSION_BYTE = 8'h41
) (
  input  logic        clk,
  input  logic        rstN,
  input  csrStrobe_t  strobe,
  input  rdSel_e      rdSel,
  input  logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  input  logic [31:0] busWdata,
  input  logic        faultCapture,
  input  logic        faultWrite,
  input  logic [31:0] faultAddr,
  output logic [31:0] busRdata,
  output logic        irqOut,
  output logic [31:0] winStart
);
  localparam logic [31:0] VER_WORD = {VERSION_BYTE, 24'h0};

  logic [31:0] ctrlReg, baseReg, tlbfReg, pgfReg, statReg, faddrReg;
  logic [31:0] arbReg, arbEnReg, maskReg;
  logic [31:0] slotReg [NUM_SLOTS];
  logic        irqReg;
  logic [31:0] winReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= VER_WORD;
      baseReg  <= '0;
      tlbfReg  <= '0;
      pgfReg   <= '0;
      arbReg   <= ARB_RESET;
      arbEnReg <= ARBEN_FORCE;
      maskReg  <= MASK_RESET;
      winReg   <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        ctrlReg <= (busWdata & CTRL_KEEP) | VER_WORD;
        winReg  <= WIN_SMALL << busWdata[4:2];
      end
      if (strobe.wrBase)  baseReg  <= busWdata & BASE_KEEP;
      if (strobe.wrTlbf)  tlbfReg  <= busWdata;
      if (strobe.wrPgf)   pgfReg   <= busWdata;
      if (strobe.wrArb)   arbReg   <= (busWdata & ARB_KEEP) | ARB_FORCE;
      if (strobe.wrArbEn) arbEnReg <= (busWdata & ARBEN_KEEP) | ARBEN_FORCE;
      if (strobe.wrMask)  maskReg  <= maskReg | (busWdata & MASK_KEEP);
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                slotReg[g] <= '0;
      else if (strobe.wrSlot[g]) slotReg[g] <= busWdata & SLOT_KEEP;
    end
  end

  // Capture from the translator overrides any bus action on the fault registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg  <= STAT_FORCE;
      faddrReg <= '0;
      irqReg   <= 1'b0;
    end else if (faultCapture) begin
      statReg  <= CAP_STATUS | (faultWrite ? 32'h0 : CAP_RDBIT);
      faddrReg <= faultAddr & PAGE_KEEP;
      irqReg   <= 1'b1;
    end else begin
      if (strobe.wrStat)     statReg  <= (busWdata & STAT_KEEP) | STAT_FORCE;
      if (strobe.wrFaddr)    faddrReg <= busWdata;
      if (strobe.faultTouch) irqReg   <= 1'b0;
    end
  end

  always_comb begin
    case (rdSel)
      RD_CTRL:  busRdata = ctrlReg;
      RD_BASE:  busRdata = baseReg;
      RD_TLBF:  busRdata = tlbfReg;
      RD_PGF:   busRdata = pgfReg;
      RD_STAT:  busRdata = statReg;
      RD_FADDR: busRdata = faddrReg;
      RD_ARB:   busRdata = arbReg;
      RD_SLOT:  busRdata = slotReg[slotIdx];
      RD_ARBEN: busRdata = arbEnReg;
      RD_MASK:  busRdata = maskReg;
      default:  busRdata = '0;
    endcase
  end

  assign irqOut   = irqReg;
  assign winStart = winReg;

endmodule

// File: rtl/ioxlat_csr.sv
module ioxlat_csr
  import ioxlat_csr_pkg::*;
#(
  parameter int         ADDR_W       = 16,
  parameter logic [7:0] VERSION_BYTE = 8'h41
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              faultCapture,
  input  logic              faultWrite,
  input  logic [31:0]       faultAddr,
  output logic              irqOut,
  output logic [31:0]       winStart
);
  csrStrobe_t strobe;
  rdSel_e     rdSel;
  logic [$clog2(NUM_SLOTS)-1:0] slotIdx;

  ioxlat_csr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busBe   (busBe),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .slotIdx (slotIdx)
  );

  ioxlat_csr_dp #(.VERSION_BYTE(VERSION_BYTE)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .slotIdx     (slotIdx),
    .busWdata    (busWdata),
    .faultCapture(faultCapture),
    .faultWrite  (faultWrite),
    .faultAddr   (faultAddr),
    .busRdata    (busRdata),
    .irqOut      (irqOut),
    .winStart    (winStart)
  );

endmodule

// File: rtl/ioxlat_csr_chk.sv
module ioxlat_csr_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busBe,
  input logic [31:0]       busRdata,
  input logic              faultCapture,
  input logic              irqOut,
  input logic [31:0]       winStart
);
  logic fullAcc, faultReg, ctrlWr;
  assign fullAcc  = busSel && (&busBe);
  assign faultReg = (busAddr == ADDR_W'('h1000)) || (busAddr == ADDR_W'('h1004));
  assign ctrlWr   = fullAcc && busWrite && (busAddr == ADDR_W'(0));

  // R10
  capture_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultCapture |=> irqOut);

  // R10
  irq_rise_needs_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(faultCapture));

  // R11
  touch_clears_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullAcc && faultReg && !faultCapture) |=> !irqOut);

  // R3
  window_moves_on_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(winStart) |-> $past(ctrlWr));

  // R8
  partial_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && !(&busBe)) |-> (busRdata == 32'h0));

  // R3
  window_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    winStart[23:0] == 24'h0);

endmodule

bind ioxlat_csr ioxlat_csr_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_ioxlat_csr.sv
module test_ioxlat_csr;
  localparam logic [7:0] VER = 8'h41;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        faultCapture = 1'b0, faultWrite = 1'b0;
  logic [31:0] faultAddr = '0;
  logic        irqOut;
  logic [31:0] winStart;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model: offset-indexed storage
  logic [31:0] mReg [int];
  bit          mIrq;
  logic [31:0] mWin;

  always #4 clk = ~clk;

  ioxlat_csr #(.ADDR_W(16), .VERSION_BYTE(VER)) i_ioxlat_csr (.*);

  function automatic bit known(int a);
    return a == 'h0 || a == 'h4 || a == 'h14 || a == 'h18 || a == 'h1000 ||
           a == 'h1004 || a == 'h1008 || a == 'h1010 || a == 'h1014 ||
           a == 'h1018 || a == 'h101C || a == 'h2000 || a == 'h3018;
  endfunction

  function automatic logic [31:0] mRead(int a, logic [3:0] be);
    if (be != 4'hF || !known(a)) return 32'h0;
    return mReg[a];
  endfunction

  task automatic modelReset();
    mReg.delete();
    foreach (mReg[k]) mReg[k] = 0;
    mReg['h0] = {VER, 24'h0};  mReg['h4] = 0; mReg['h14] = 0; mReg['h18] = 0;
    mReg['h1000] = 32'h0080_0000; mReg['h1004] = 0; mReg['h1008] = 32'h3;
    mReg['h1010] = 0; mReg['h1014] = 0; mReg['h1018] = 0; mReg['h101C] = 0;
    mReg['h2000] = 32'h8; mReg['h3018] = 32'h2300_0000;
    mIrq = 0; mWin = 0;
  endtask

  task automatic modelClock(bit sel, bit wr, int a, logic [31:0] d, logic [3:0] be,
                            bit cap, bit capWr, logic [31:0] ca);
    if (sel && be == 4'hF && known(a)) begin
      if (wr) begin
        if (a == 'h0) begin
          mReg[a] = (d & 32'h1D) | {VER, 24'h0};
          mWin = 32'hFFFF_FFFF - ((32'h0100_0000 << d[4:2]) - 1);
        end
        else if (a == 'h4) mReg[a] = d & 32'h07FF_FC00;
        else if (a == 'h1000) mReg[a] = (d & 32'hFF0F_FFFF) | 32'h0080_0000;
        else if (a == 'h1008) mReg[a] = (d & 32'h801F_000F) | 1;
        else if (a >= 'h1010 && a <= 'h101C) mReg[a] = d & 32'h0001_0003;
        else if (a == 'h2000) mReg[a] = (d & 32'h001F_0000) | 8;
        else if (a == 'h3018) mReg[a] = mReg[a] | (d & 32'h00FF_FFFF);
        else mReg[a] = d;
      end
      if (a == 'h1000 || a == 'h1004) mIrq = 0;
    end
    if (cap) begin
      mReg['h1000] = capWr ? 32'hC082_0000 : 32'hC086_0000;
      mReg['h1004] = {ca[31:12], 12'h0};
      mIrq = 1;
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit sel, bit wr, int a, logic [31:0] d, logic [3:0] be,
                      bit cap, bit capWr, logic [31:0] ca, string tag);
    busSel = sel; busWrite = wr; busAddr = 16'(a); busWdata = d; busBe = be;
    faultCapture = cap; faultWrite = capWr; faultAddr = ca;
    #1;
    if (sel && !wr) check(tag, busRdata, mRead(a, be));
    @(posedge clk);
    modelClock(sel, wr, a, d, be, cap, capWr, ca);
    @(negedge clk);
    busSel = 0; faultCapture = 0;
    check(tag, {31'h0, irqOut}, {31'h0, mIrq});
    check("R3", winStart, mWin);
  endtask

  task automatic wr(int a, logic [31:0] d, string tag);
    step(1, 1, a, d, 4'hF, 0, 0, 0, tag);
  endtask
  task automatic rd(int a, string tag);
    step(1, 0, a, 0, 4'hF, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1", {31'h0, irqOut}, 32'h0);
    check("R1", winStart, 32'h0);
    foreach (mReg[k]) rd(k, "R1");

    // R2 / R3: control mask and every window code
    for (int c = 0; c < 8; c++) begin
      wr('h0, 32'hFFFF_FFE2 | (c << 2), "R2");
      rd('h0, "R2");
      check("R3", winStart, 32'hFF00_0000 << c);
    end
    wr('h0, 32'h0000_0001, "R2"); rd('h0, "R2");

    // R4
    wr('h4, 32'hFFFF_FFFF, "R4"); rd('h4, "R4");
    wr('h14, 32'hDEAD_BEEF, "R4"); rd('h14, "R4");
    wr('h18, 32'h1234_5678, "R4"); rd('h18, "R4");
    // R5
    wr('h1000, 32'h0, "R5"); rd('h1000, "R5");
    wr('h1000, 32'hFFFF_FFFF, "R5"); rd('h1000, "R5");
    // R6
    wr('h1008, 32'h0, "R6"); rd('h1008, "R6");
    wr('h1008, 32'hFFFF_FFFF, "R6"); rd('h1008, "R6");
    wr('h2000, 32'hFFFF_FFFF, "R6"); rd('h2000, "R6");
    wr('h2000, 32'h0, "R6"); rd('h2000, "R6");
    for (int s = 0; s < 4; s++) begin
      wr('h1010 + 4 * s, 32'hFFFF_FFF0 | s, "R6");
    end
    for (int s = 0; s < 4; s++) rd('h1010 + 4 * s, "R6");
    // R7
    wr('h3018, 32'hFF00_00F0, "R7"); wr('h3018, 32'h0000_000F, "R7");
    wr('h3018, 32'h0, "R7"); rd('h3018, "R7");
    check("R7", mRead('h3018, 4'hF), 32'h2300_00FF);

    // R8: partial byte enables
    step(1, 1, 'h4, 32'h0, 4'b0111, 0, 0, 0, "R8"); rd('h4, "R8");
    step(1, 0, 'h4, 0, 4'b1110, 0, 0, 0, "R8");
    step(1, 1, 'h0, 32'h1C, 4'b1101, 0, 0, 0, "R8"); rd('h0, "R8");
    // R9: unlisted and unaligned offsets
    wr('h8, 32'hFFFF_FFFF, "R9"); rd('h8, "R9");
    wr('h1002, 32'hFFFF_FFFF, "R9"); rd('h1002, "R9");
    rd('h1020, "R9"); rd('h4, "R9"); rd('h1000, "R9");

    // R10: capture on a read fault, then on a write fault
    step(0, 0, 0, 0, 0, 1, 0, 32'hABCD_E123, "R10");
    rd('h1004, "R10");
    step(0, 0, 0, 0, 0, 1, 0, 32'h1111_2FFF, "R10");
    step(1, 0, 'h1000, 0, 4'b0011, 0, 0, 0, "R8");   // partial: irq stays
    rd('h1000, "R11");
    rd('h1004, "R10");
    step(0, 0, 0, 0, 0, 1, 1, 32'h0000_5ABC, "R10");
    wr('h1004, 32'h7777_7777, "R11"); rd('h1004, "R11");
    step(0, 0, 0, 0, 0, 1, 1, 32'h0000_6000, "R10");
    wr('h1000, 32'h0, "R11"); rd('h1000, "R11");

    // R12: collisions of capture and bus access
    step(1, 1, 'h1000, 32'h0, 4'hF, 1, 0, 32'h4444_4000, "R12");
    rd('h1000, "R12");
    step(1, 1, 'h1004, 32'h5555_5555, 4'hF, 1, 1, 32'h8888_8123, "R12");
    rd('h1004, "R12"); rd('h1000, "R12");
    step(1, 0, 'h1004, 0, 4'hF, 1, 0, 32'h9999_9999, "R12");
    rd('h1004, "R11");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule